// File: doc/BRIEF.md
# Data Access Watchpoint Unit

This block sits beside a processor's data port and watches every load and store. Two watchpoints are available. Each one holds an address and a 32-bit compare value, and it has its own read enable, write enable, byte-lane mask and value-match mode. When a valid access hits a watchpoint, the unit sets a sticky status bit. Loads set the read status of that watchpoint and stores set its write status. The bit stays set until software clears it.

Address matching is exact by default. When range mode is on, both watchpoints match any address in the window that starts at watchpoint 1's address (included) and ends at watchpoint 2's address (excluded). If a watchpoint's byte-lane mask is non-zero, an address hit counts only when the data word also passes that watchpoint's value check. The check can require every selected lane to match, or any one selected lane to match. A third mode switches value-qualified events off.

Top module: `dwatch_top`

## Requirements
- R1: With an empty byte mask and range mode off, a valid load whose address equals watchpoint n's address sets st_rd[n-1] when rd_en[n-1] is 1. Any other address leaves the bit unchanged.
- R2: With an empty byte mask and range mode off, a valid store whose address equals watchpoint n's address sets st_wr[n-1] when wr_en[n-1] is 1.
- R3: A load with rd_en[n-1]=0 does not set st_rd[n-1]. When both enables of a watchpoint are 0, its two status bits hold their values.
- R4: A store never sets a read status bit, and a load never sets a write status bit.
- R5: All status bits are 0 after reset. A status bit stays set until its clear input (clr_rd/clr_wr, bit n-1) is high at a clock edge with no new event, and it then reads 0.
- R6: With range_en=1, both watchpoints hit an address A when wp_addr[0] <= A < wp_addr[1], using unsigned compare. A = wp_addr[1] and A = wp_addr[0]-1 do not hit.
- R7: Mode 2'b01 with a non-zero mask is a logical AND. Mask bit k selects byte lane k, which is data bits 8k+7:8k. Every selected lane of the data must equal the same lane of the compare value, or no event is raised.
- R8: Modes 2'b10 and 2'b11 with a non-zero mask are a logical OR: at least one selected lane must match.
- R9: Mode 2'b00 with a non-zero mask raises no event for that watchpoint, whatever the address and data.
- R10: When the byte mask is 0, value checking is off and the data word has no effect on the event.
- R11: Status changes at the first clock edge after the valid access, not before. An event and a clear of the same bit in the same cycle leave the bit set.
- R12: A cycle with acc_valid=0 sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data access present this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_data | input | DATA_W | Load or store data word |
| wp_addr | input | 2 x ADDR_W | Watchpoint addresses; index 0 is watchpoint 1 (range lower bound), index 1 is watchpoint 2 (range upper bound) |
| wp_val | input | 2 x DATA_W | Value compare words |
| wp_be | input | 2 x DATA_W/8 | Byte-lane masks; non-zero enables value checking |
| wp_mode | input | 2 x 2 | Value match mode: 00 off, 01 all lanes, 10/11 any lane |
| rd_en | input | 2 | Read watch enable per watchpoint |
| wr_en | input | 2 | Write watch enable per watchpoint |
| range_en | input | 1 | Range address mode for both watchpoints |
| clr_rd | input | 2 | Clear read status per watchpoint |
| clr_wr | input | 2 | Clear write status per watchpoint |
| st_rd | output | 2 | Sticky read hit status |
| st_wr | output | 2 | Sticky write hit status |

## Verification
Directed loads and stores run against exact addresses, against off-by-one neighbours and against both ends of the range window, which shows whether the bounds are inclusive or exclusive. Data words are built so that some selected lanes match and one does not. The same data is then run under each match mode, so AND, OR and off give visibly different results. A random phase then mixes enables, masks, modes, clears and addresses close to the watchpoints. Every clock is compared with a behavioural model, and this exposes any wrong interaction between direction, enable and stickiness.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

   localparam int NUM_WP = 2;

   typedef enum logic [1:0] {
      VM_OFF  = 2'b00,
      VM_ALL  = 2'b01,
      VM_ANY  = 2'b10,
      VM_ANY3 = 2'b11
   } vmode_e;

endpackage

// File: rtl/dwatch_addr_cmp.sv
module dwatch_addr_cmp
   import dwatch_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter bit RANGE_SUPPORT = 1'b1
)(
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_WP-1:0][ADDR_W-1:0] wp_addr,
   input  logic                          range_en,
   output logic [NUM_WP-1:0]             hit
);

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("dwatch_addr_cmp: ADDR_W must be positive");
   end

   logic [NUM_WP-1:0] exact_hit;

   for (genvar i = 0; i < NUM_WP; i++) begin : g_exact
      assign exact_hit[i] = (addr == wp_addr[i]);
   end

   if (RANGE_SUPPORT) begin : g_range
      // one shared window: lower bound inclusive, upper bound exclusive
      logic above_lo;
      logic below_hi;
      logic in_window;
      assign above_lo  = (addr >= wp_addr[0]);
      assign below_hi  = (addr <  wp_addr[1]);
      assign in_window = above_lo & below_hi;
      assign hit = range_en ? {NUM_WP{in_window}} : exact_hit;
   end else begin : g_exact_only
      logic unused_range;
      assign unused_range = range_en;
      assign hit = exact_hit;
   end

endmodule

// File: rtl/dwatch_val_cmp.sv
module dwatch_val_cmp
   import dwatch_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
)(
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] cmp_val,
   input  logic [LANES-1:0]  lane_sel,
   input  logic [1:0]        mode,
   output logic              qual
);

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("dwatch_val_cmp: DATA_W must be a non-zero multiple of 8");
   end

   logic [LANES-1:0] lane_eq;
   logic             all_ok;
   logic             any_ok;
   logic             val_on;
   logic             mode_ok;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_eq[k] = (data[8*k +: 8] == cmp_val[8*k +: 8]);
   end

   // unselected lanes count as passing for the AND form
   assign all_ok = &(lane_eq | ~lane_sel);
   assign any_ok = |(lane_eq & lane_sel);
   assign val_on = |lane_sel;

   always_comb begin
      unique case (mode)
         VM_OFF:  mode_ok = 1'b0;
         VM_ALL:  mode_ok = all_ok;
         default: mode_ok = any_ok;
      endcase
   end

   assign qual = val_on ? mode_ok : 1'b1;

endmodule

// File: rtl/dwatch_status.sv
module dwatch_status #(
   parameter int NUM = 2
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] ev_rd,
   input  logic [NUM-1:0] ev_wr,
   input  logic [NUM-1:0] clr_rd,
   input  logic [NUM-1:0] clr_wr,
   output logic [NUM-1:0] st_rd,
   output logic [NUM-1:0] st_wr
);

   if (NUM < 1) begin : g_bad_num
      $error("dwatch_status: NUM must be positive");
   end

   // the event term is ORed last so that it wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_rd <= '0;
         st_wr <= '0;
      end else begin
         st_rd <= (st_rd & ~clr_rd) | ev_rd;
         st_wr <= (st_wr & ~clr_wr) | ev_wr;
      end
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (({st_rd, st_wr} & $past({st_rd & ~clr_rd, st_wr & ~clr_wr}))
                == $past({st_rd & ~clr_rd, st_wr & ~clr_wr}))); // R5

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (({st_rd, st_wr} & $past({clr_rd & ~ev_rd, clr_wr & ~ev_wr})) == '0)); // R5

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (({st_rd, st_wr} & $past({ev_rd, ev_wr})) == $past({ev_rd, ev_wr}))); // R11

endmodule

// File: rtl/dwatch_top.sv
module dwatch_top
   import dwatch_pkg::*;
#(
   parameter int  ADDR_W        = 32,
   parameter int  DATA_W        = 32,
   parameter bit  RANGE_SUPPORT = 1'b1,
   localparam int LANES         = DATA_W / 8
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          acc_valid,
   input  logic                          acc_write,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [DATA_W-1:0]             acc_data,
   input  logic [NUM_WP-1:0][ADDR_W-1:0] wp_addr,
   input  logic [NUM_WP-1:0][DATA_W-1:0] wp_val,
   input  logic [NUM_WP-1:0][LANES-1:0]  wp_be,
   input  logic [NUM_WP-1:0][1:0]        wp_mode,
   input  logic [NUM_WP-1:0]             rd_en,
   input  logic [NUM_WP-1:0]             wr_en,
   input  logic                          range_en,
   input  logic [NUM_WP-1:0]             clr_rd,
   input  logic [NUM_WP-1:0]             clr_wr,
   output logic [NUM_WP-1:0]             st_rd,
   output logic [NUM_WP-1:0]             st_wr
);

   if (NUM_WP != 2) begin : g_bad_wp
      $error("dwatch_top: range mode needs exactly two watchpoints");
   end

   logic [NUM_WP-1:0] addr_hit;
   logic [NUM_WP-1:0] val_ok;
   logic [NUM_WP-1:0] ev_rd;
   logic [NUM_WP-1:0] ev_wr;
   logic              is_load;
   logic              is_store;

   assign is_load  = acc_valid & ~acc_write;
   assign is_store = acc_valid &  acc_write;

   dwatch_addr_cmp #(
      .ADDR_W        (ADDR_W),
      .RANGE_SUPPORT (RANGE_SUPPORT)
   ) u_addr (
      .addr     (acc_addr),
      .wp_addr  (wp_addr),
      .range_en (range_en),
      .hit      (addr_hit)
   );

   for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
      dwatch_val_cmp #(
         .DATA_W (DATA_W)
      ) u_val (
         .data     (acc_data),
         .cmp_val  (wp_val[i]),
         .lane_sel (wp_be[i]),
         .mode     (wp_mode[i]),
         .qual     (val_ok[i])
      );

      assign ev_rd[i] = is_load  & rd_en[i] & addr_hit[i] & val_ok[i];
      assign ev_wr[i] = is_store & wr_en[i] & addr_hit[i] & val_ok[i];

      AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         ((wp_be[i] != '0) && (wp_mode[i] == VM_OFF)) |-> !(ev_rd[i] || ev_wr[i])); // R9

      AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_en[i] && !wr_en[i] && !clr_rd[i] && !clr_wr[i])
            |=> ($stable(st_rd[i]) && $stable(st_wr[i]))); // R3
   end

   dwatch_status #(
      .NUM (NUM_WP)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_rd  (ev_rd),
      .ev_wr  (ev_wr),
      .clr_rd (clr_rd),
      .clr_wr (clr_wr),
      .st_rd  (st_rd),
      .st_wr  (st_wr)
   );

   AST_STORE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |=> ((st_rd & ~$past(st_rd)) == '0)); // R4

   AST_LOAD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> ((st_wr & ~$past(st_wr)) == '0)); // R4

   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (({st_rd, st_wr} & ~$past({st_rd, st_wr})) == '0)); // R12

endmodule

// File: tb/dwatch_top_tb.sv
module dwatch_top_tb;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic             acc_write = 1'b0;
   logic [31:0]      acc_addr = '0;
   logic [31:0]      acc_data = '0;
   logic [1:0][31:0] wp_addr = '0;
   logic [1:0][31:0] wp_val = '0;
   logic [1:0][3:0]  wp_be = '0;
   logic [1:0][1:0]  wp_mode = '0;
   logic [1:0]       rd_en = '0;
   logic [1:0]       wr_en = '0;
   logic             range_en = 1'b0;
   logic [1:0]       clr_rd = '0;
   logic [1:0]       clr_wr = '0;
   logic [1:0]       st_rd;
   logic [1:0]       st_wr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dwatch_top u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_data(acc_data), .wp_addr(wp_addr), .wp_val(wp_val),
      .wp_be(wp_be), .wp_mode(wp_mode), .rd_en(rd_en), .wr_en(wr_en),
      .range_en(range_en), .clr_rd(clr_rd), .clr_wr(clr_wr),
      .st_rd(st_rd), .st_wr(st_wr)
   );

   // ---------------- behavioural reference model ----------------
   logic [1:0] m_rd;
   logic [1:0] m_wr;

   function automatic bit data_ok(int n);
      int sel = 0;
      int hits = 0;
      if (wp_be[n] == 4'b0) return 1'b1;
      for (int k = 0; k < 4; k++) begin
         if (wp_be[n][k]) begin
            sel++;
            if (acc_data[8*k +: 8] == wp_val[n][8*k +: 8]) hits++;
         end
      end
      if (wp_mode[n] == 2'b00) return 1'b0;
      if (wp_mode[n] == 2'b01) return hits == sel;
      return hits > 0;
   endfunction

   function automatic bit addr_ok(int n);
      if (range_en) return (acc_addr >= wp_addr[0]) && (acc_addr < wp_addr[1]);
      return acc_addr == wp_addr[n];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rd <= '0;
         m_wr <= '0;
      end else begin
         for (int n = 0; n < 2; n++) begin
            m_rd[n] <= (m_rd[n] & ~clr_rd[n]) |
                       (acc_valid && !acc_write && rd_en[n] && addr_ok(n) && data_ok(n));
            m_wr[n] <= (m_wr[n] & ~clr_wr[n]) |
                       (acc_valid && acc_write && wr_en[n] && addr_ok(n) && data_ok(n));
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (st_rd !== m_rd || st_wr !== m_wr) begin
            errors++;
            $display("FAIL R1/R2/R4/R7/R8 model: st_rd=%b st_wr=%b expected %b %b",
                     st_rd, st_wr, m_rd, m_wr);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic expect_st(input string tag, input logic [1:0] erd, input logic [1:0] ewr);
      checks++;
      if (st_rd !== erd || st_wr !== ewr) begin
         errors++;
         $display("FAIL %s: st_rd=%b st_wr=%b expected %b %b", tag, st_rd, st_wr, erd, ewr);
      end
   endtask

   task automatic acc(input logic v, input logic w, input logic [31:0] a, input logic [31:0] d);
      acc_valid = v;
      acc_write = w;
      acc_addr  = a;
      acc_data  = d;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic clear_all();
      clr_rd = 2'b11;
      clr_wr = 2'b11;
      acc_valid = 1'b0;
      @(negedge clk);
      clr_rd = 2'b00;
      clr_wr = 2'b00;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      wp_addr[0] = 32'h0000_1000;
      wp_addr[1] = 32'h0000_2000;
      wp_mode    = {2'b01, 2'b01};
      rd_en = 2'b11;
      wr_en = 2'b11;
      repeat (3) @(negedge clk);
      expect_st("R5 reset", 2'b00, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);

      // exact address, plain
      acc(1, 0, 32'h1000, 32'h0);        expect_st("R1 load hit wp1", 2'b01, 2'b00);
      acc(1, 1, 32'h2000, 32'h0);        expect_st("R2 store hit wp2", 2'b01, 2'b10);
      acc(1, 0, 32'h1001, 32'h0);        expect_st("R1 near miss", 2'b01, 2'b10);
      acc(0, 0, 32'h2000, 32'h0);        expect_st("R12 idle", 2'b01, 2'b10);
      clear_all();                       expect_st("R5 clear", 2'b00, 2'b00);

      // enables
      rd_en = 2'b00;
      acc(1, 0, 32'h1000, 32'h0);        expect_st("R3 read disabled", 2'b00, 2'b00);
      acc(1, 1, 32'h1000, 32'h0);        expect_st("R2 store wp1", 2'b00, 2'b01);
      wr_en = 2'b00;
      acc(1, 1, 32'h1000, 32'h0);        expect_st("R3 both off store", 2'b00, 2'b01);
      acc(1, 0, 32'h1000, 32'h0);        expect_st("R3 both off load", 2'b00, 2'b01);
      clear_all();
      rd_en = 2'b01; wr_en = 2'b00;
      acc(1, 1, 32'h1000, 32'h0);        expect_st("R4 store no read", 2'b00, 2'b00);
      rd_en = 2'b00; wr_en = 2'b01;
      acc(1, 0, 32'h1000, 32'h0);        expect_st("R4 load no write", 2'b00, 2'b00);

      // range
      rd_en = 2'b11; wr_en = 2'b11; range_en = 1'b1;
      acc(1, 0, 32'h1FFF, 32'h0);        expect_st("R6 top of window", 2'b11, 2'b00);
      clear_all();
      acc(1, 0, 32'h2000, 32'h0);        expect_st("R6 upper excluded", 2'b00, 2'b00);
      acc(1, 0, 32'h1000, 32'h0);        expect_st("R6 lower included", 2'b11, 2'b00);
      clear_all();
      acc(1, 1, 32'h0FFF, 32'h0);        expect_st("R6 below window", 2'b00, 2'b00);
      acc(1, 1, 32'h1800, 32'h0);        expect_st("R6 mid window store", 2'b00, 2'b11);
      clear_all();
      range_en = 1'b0;

      // value compare
      wp_val[0] = 32'hAABB_CCDD;
      wp_be[0]  = 4'b0101;
      wp_mode[0] = 2'b01;
      acc(1, 0, 32'h1000, 32'h11BB_22DD); expect_st("R7 all selected match", 2'b01, 2'b00);
      clear_all();
      acc(1, 0, 32'h1000, 32'h11BB_22DE); expect_st("R7 one lane off", 2'b00, 2'b00);
      wp_mode[0] = 2'b10;
      acc(1, 0, 32'h1000, 32'h00BB_0000); expect_st("R8 any lane", 2'b01, 2'b00);
      clear_all();
      acc(1, 0, 32'h1000, 32'h0000_0000); expect_st("R8 no lane", 2'b00, 2'b00);
      wp_mode[0] = 2'b11;
      acc(1, 0, 32'h1000, 32'h0000_00DD); expect_st("R8 mode 11", 2'b01, 2'b00);
      clear_all();
      wp_mode[0] = 2'b00;
      acc(1, 0, 32'h1000, 32'hAABB_CCDD); expect_st("R9 mode off", 2'b00, 2'b00);
      wp_be[0] = 4'b0000;
      acc(1, 0, 32'h1000, 32'h1234_0000); expect_st("R10 mask empty", 2'b01, 2'b00);
      clear_all();
      wp_val[1] = 32'h1234_5678;
      wp_be[1]  = 4'b1111;
      wp_mode[1] = 2'b01;
      acc(1, 1, 32'h2000, 32'h1234_5678); expect_st("R7 wp2 full word", 2'b00, 2'b10);
      clear_all();
      acc(1, 1, 32'h2000, 32'h1234_5679); expect_st("R7 wp2 low lane off", 2'b00, 2'b00);

      // timing and clear-vs-event
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h1000; acc_data = 32'h0;
      #1;                                 expect_st("R11 not before edge", 2'b00, 2'b00);
      @(negedge clk);
      acc_valid = 1'b0;                   expect_st("R11 after edge", 2'b01, 2'b00);
      clr_rd = 2'b01;
      acc(1, 0, 32'h1000, 32'h0);         expect_st("R11 event beats clear", 2'b01, 2'b00);
      acc(0, 0, 32'h1000, 32'h0);         expect_st("R5 clear alone", 2'b00, 2'b00);
      clr_rd = 2'b00;

      // random phase, compared to the model every clock
      for (int cyc = 0; cyc < 3000; cyc++) begin
         if (cyc % 16 == 0) begin
            rd_en = 2'($urandom); wr_en = 2'($urandom);
            range_en = ($urandom % 4) == 0;
            for (int n = 0; n < 2; n++) begin
               wp_be[n]   = ($urandom % 3 == 0) ? 4'b0 : 4'($urandom);
               wp_mode[n] = 2'($urandom);
               wp_val[n]  = $urandom;
            end
         end
         case ($urandom % 6)
            0: acc_addr = 32'h1000;
            1: acc_addr = 32'h2000;
            2: acc_addr = 32'h1FFF;
            3: acc_addr = 32'h0FFF;
            4: acc_addr = 32'h1800;
            default: acc_addr = 32'h1001;
         endcase
         begin
            logic [31:0] d;
            d = wp_val[$urandom % 2];
            if ($urandom % 2) d[8*($urandom % 4) +: 8] = 8'($urandom);
            acc_data = d;
         end
         acc_valid = ($urandom % 4) != 0;
         acc_write = 1'($urandom);
         clr_rd = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         clr_wr = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         @(negedge clk);
      end
      finish_run();
   end

endmodule